// File: doc/BRIEF.md
# Legacy System Control Port Block

This block sits on a byte-wide I/O bus and answers a small group of legacy system control addresses. Some of the addresses hold control bits that drive pins: a processor reset request, a memory-map mode level and a drive activity light. Others hold small values that software writes and reads back, such as the endian flag and a 4-bit system control field. A set of read-only addresses returns fixed board identification bytes. Two write-only addresses raise single-cycle toggle pulses toward an external NVRAM lock controller. A cache-invalidate address accepts writes and does nothing with them.

The bus has an address, write data, a write strobe, a read strobe and registered read data. Each strobe is sampled on a rising clock edge. Reads of addresses the block does not decode return 0xFF. Writes to such addresses are dropped.

Top module: `sysport_regs`

## Requirements
- R1: While `rst_n` is low and after it is released, `cpu_reset`, `map_mode`, `activity_led`, `lock1_toggle`, `lock2_toggle` and `rdata` are all 0, and every stored field is 0.
- R2: A write to address 0x0092 sets `cpu_reset` to bit 0 of the write data from the clock edge that captures the write. A write with bit 0 clear deasserts it.
- R3: A write to 0x0092 stores bit 1 of the write data as the endian flag. A read of 0x0092 returns the flag in bit 1, with every other bit 0.
- R4: A write to the system control address 0x081C keeps only write-data bits 3:0. A read of that address returns those four bits, with bits 7:4 zero.
- R5: A write to the map-mode address 0x0850 keeps only write-data bit 0. That bit drives `map_mode`, and a read returns it in bit 0 with bits 7:1 zero.
- R6: Reads of the identity addresses return constants: 0x0800 gives 0xEF (CPU configuration), 0x0802 gives 0xAD (module feature), 0x0803 gives 0xE0 (module status), 0x0804 gives 0x39 (extended feature) and 0x081D gives 0x03 (cache status).
- R7: A write to the activity-light address 0x0808 stores write-data bit 0, which drives `activity_led`.
- R8: A write to 0x0810 makes `lock1_toggle` high for exactly the one cycle after the capturing edge, and a write to 0x0812 does the same on `lock2_toggle`. The two pulses are never high together.
- R9: A read of any address outside {0x0092, 0x0800, 0x0802, 0x0803, 0x0804, 0x081C, 0x081D, 0x0850} returns 0xFF. This includes the write-only addresses 0x0808, 0x0810, 0x0812 and 0x0814.
- R10: Writes to the identity addresses, to the cache-invalidate address 0x0814 and to undecoded addresses change no output and no stored field.
- R11: `rdata` changes only on an edge where `rd_en` is high. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | I/O port address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle high |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| cpu_reset | output | 1 | Processor reset request level |
| map_mode | output | 1 | Memory-map mode level |
| activity_led | output | 1 | Drive activity light |
| lock1_toggle | output | 1 | One-cycle toggle request for lock 1 |
| lock2_toggle | output | 1 | One-cycle toggle request for lock 2 |

## Verification
Every result is due one edge after the strobe that causes it. Read data, the level outputs and the lock pulses are all registered, and a lock pulse falls again at the edge after that. The bench drives each access on a falling edge, holds it across one rising edge and samples at the next falling edge, which is exactly one register stage later. For the pulses it samples once more a cycle after that to confirm they have fallen. Ignored writes are checked by reading back every stored field and watching every output after the write.

// File: rtl/sysport_regs.sv
module sysport_regs #(
  parameter int          AW        = 16,
  parameter logic [15:0] A_PORT92  = 16'h0092,
  parameter logic [15:0] A_CPUCFG  = 16'h0800,
  parameter logic [15:0] A_FEAT    = 16'h0802,
  parameter logic [15:0] A_STAT    = 16'h0803,
  parameter logic [15:0] A_XFEAT   = 16'h0804,
  parameter logic [15:0] A_LIGHT   = 16'h0808,
  parameter logic [15:0] A_LOCK1   = 16'h0810,
  parameter logic [15:0] A_LOCK2   = 16'h0812,
  parameter logic [15:0] A_INVAL   = 16'h0814,
  parameter logic [15:0] A_SYSCTL  = 16'h081C,
  parameter logic [15:0] A_CSTAT   = 16'h081D,
  parameter logic [15:0] A_MAP     = 16'h0850,
  parameter logic [7:0]  V_CPUCFG  = 8'hEF,
  parameter logic [7:0]  V_FEAT    = 8'hAD,
  parameter logic [7:0]  V_STAT    = 8'hE0,
  parameter logic [7:0]  V_XFEAT   = 8'h39,
  parameter logic [7:0]  V_CSTAT   = 8'h03
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [7:0]    rdata,
  output logic          cpu_reset,
  output logic          map_mode,
  output logic          activity_led,
  output logic          lock1_toggle,
  output logic          lock2_toggle
);

  localparam logic [7:0] UNMAPPED = 8'hFF;

  logic       endian_q;
  logic [3:0] sysctl_q;
  logic [7:0] rd_mux;

  wire hit_lock1 = wr_en && (addr == AW'(A_LOCK1));
  wire hit_lock2 = wr_en && (addr == AW'(A_LOCK2));

  always_comb begin
    case (addr)
      AW'(A_PORT92): rd_mux = {6'b0, endian_q, 1'b0};
      AW'(A_CPUCFG): rd_mux = V_CPUCFG;
      AW'(A_FEAT):   rd_mux = V_FEAT;
      AW'(A_STAT):   rd_mux = V_STAT;
      AW'(A_XFEAT):  rd_mux = V_XFEAT;
      AW'(A_SYSCTL): rd_mux = {4'b0, sysctl_q};
      AW'(A_CSTAT):  rd_mux = V_CSTAT;
      AW'(A_MAP):    rd_mux = {7'b0, map_mode};
      default:       rd_mux = UNMAPPED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_reset    <= 1'b0;
      endian_q     <= 1'b0;
      activity_led <= 1'b0;
      sysctl_q     <= 4'h0;
      map_mode     <= 1'b0;
      lock1_toggle <= 1'b0;
      lock2_toggle <= 1'b0;
      rdata        <= 8'h00;
    end else begin
      lock1_toggle <= hit_lock1;
      lock2_toggle <= hit_lock2;
      if (wr_en) begin
        case (addr)
          AW'(A_PORT92): begin
            cpu_reset <= wdata[0];
            endian_q  <= wdata[1];
          end
          AW'(A_LIGHT):  activity_led <= wdata[0];
          AW'(A_SYSCTL): sysctl_q     <= wdata[3:0];
          AW'(A_MAP):    map_mode     <= wdata[0];
          default: ;
        endcase
      end
      if (rd_en) rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/sysport_regs_checker.sv
module sysport_regs_checker #(
  parameter int          AW       = 16,
  parameter logic [15:0] A_PORT92 = 16'h0092,
  parameter logic [15:0] A_LOCK1  = 16'h0810,
  parameter logic [15:0] A_LOCK2  = 16'h0812,
  parameter logic [15:0] A_SYSCTL = 16'h081C,
  parameter logic [15:0] A_MAP    = 16'h0850
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [7:0]    rdata,
  input logic          cpu_reset,
  input logic          map_mode,
  input logic          lock1_toggle,
  input logic          lock2_toggle
);

  p_reset_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(A_PORT92)) |=> $stable(cpu_reset));

  p_endian_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(A_PORT92)) |=> ((rdata & 8'hFD) == 8'h00));

  p_sysctl_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(A_SYSCTL)) |=> (rdata[7:4] == 4'h0));

  p_map_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(A_MAP)) |=> $stable(map_mode));

  p_lock1_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(A_LOCK1)) |=> !lock1_toggle);

  p_lock2_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(A_LOCK2)) |=> !lock2_toggle);

  p_lock_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lock1_toggle, lock2_toggle}) <= 1);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

bind sysport_regs sysport_regs_checker #(
  .AW(AW), .A_PORT92(A_PORT92), .A_LOCK1(A_LOCK1), .A_LOCK2(A_LOCK2),
  .A_SYSCTL(A_SYSCTL), .A_MAP(A_MAP)
) u_checker (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .cpu_reset(cpu_reset), .map_mode(map_mode),
  .lock1_toggle(lock1_toggle), .lock2_toggle(lock2_toggle)
);

// File: tb/sysport_regs_bench.sv
`timescale 1ns/1ps
module sysport_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic        cpu_reset, map_mode, activity_led, lock1_toggle, lock2_toggle;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sysport_regs u_sysport_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .cpu_reset(cpu_reset), .map_mode(map_mode),
    .activity_led(activity_led), .lock1_toggle(lock1_toggle),
    .lock2_toggle(lock2_toggle)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset_state();
    check("R1 cpu_reset", {7'b0, cpu_reset}, 8'h00);
    check("R1 map_mode", {7'b0, map_mode}, 8'h00);
    check("R1 activity_led", {7'b0, activity_led}, 8'h00);
    check("R1 locks", {6'b0, lock1_toggle, lock2_toggle}, 8'h00);
    check("R1 rdata", rdata, 8'h00);
  endtask

  task automatic t_port92();
    logic [7:0] d;
    rd(16'h0092, d);  check("R1 endian flag after reset", d, 8'h00);
    wr(16'h0092, 8'h01); check("R2 reset asserted", {7'b0, cpu_reset}, 8'h01);
    wr(16'h0092, 8'h00); check("R2 reset deasserted", {7'b0, cpu_reset}, 8'h00);
    wr(16'h0092, 8'h02); rd(16'h0092, d); check("R3 endian read", d, 8'h02);
    check("R2 reset stays low with bit0 clear", {7'b0, cpu_reset}, 8'h00);
    wr(16'h0092, 8'hFF); rd(16'h0092, d); check("R3 other bits zero", d, 8'h02);
    check("R2 reset with 0xFF", {7'b0, cpu_reset}, 8'h01);
    wr(16'h0092, 8'h00); rd(16'h0092, d); check("R3 endian cleared", d, 8'h00);
  endtask

  task automatic t_sysctl();
    logic [7:0] d;
    wr(16'h081C, 8'hA5); rd(16'h081C, d); check("R4 low nibble A5", d, 8'h05);
    wr(16'h081C, 8'hFC); rd(16'h081C, d); check("R4 low nibble FC", d, 8'h0C);
  endtask

  task automatic t_map();
    logic [7:0] d;
    wr(16'h0850, 8'hFF); check("R5 map_mode set", {7'b0, map_mode}, 8'h01);
    rd(16'h0850, d); check("R5 map read", d, 8'h01);
    wr(16'h0850, 8'hFE); check("R5 map_mode clear", {7'b0, map_mode}, 8'h00);
    rd(16'h0850, d); check("R5 map read clear", d, 8'h00);
  endtask

  task automatic t_ids();
    logic [7:0] d;
    rd(16'h0800, d); check("R6 cpu cfg", d, 8'hEF);
    rd(16'h0802, d); check("R6 feature", d, 8'hAD);
    rd(16'h0803, d); check("R6 status", d, 8'hE0);
    rd(16'h0804, d); check("R6 ext feature", d, 8'h39);
    rd(16'h081D, d); check("R6 cache status", d, 8'h03);
  endtask

  task automatic t_light();
    wr(16'h0808, 8'h01); check("R7 led on", {7'b0, activity_led}, 8'h01);
    wr(16'h0808, 8'hFE); check("R7 led off", {7'b0, activity_led}, 8'h00);
  endtask

  task automatic t_locks();
    wr(16'h0810, 8'h00);
    check("R8 lock1 pulse", {6'b0, lock1_toggle, lock2_toggle}, 8'h02);
    @(negedge clk);
    check("R8 lock1 one cycle", {6'b0, lock1_toggle, lock2_toggle}, 8'h00);
    wr(16'h0812, 8'h55);
    check("R8 lock2 pulse", {6'b0, lock1_toggle, lock2_toggle}, 8'h01);
    @(negedge clk);
    check("R8 lock2 one cycle", {6'b0, lock1_toggle, lock2_toggle}, 8'h00);
  endtask

  task automatic t_unmapped_reads();
    logic [7:0] d;
    rd(16'h0801, d); check("R9 gap 0801", d, 8'hFF);
    rd(16'h0808, d); check("R9 light write-only", d, 8'hFF);
    rd(16'h0810, d); check("R9 lock1 write-only", d, 8'hFF);
    rd(16'h0814, d); check("R9 invalidate write-only", d, 8'hFF);
    rd(16'h0000, d); check("R9 address 0", d, 8'hFF);
  endtask

  task automatic t_ignored_writes();
    logic [7:0] d;
    wr(16'h081C, 8'h03); wr(16'h0850, 8'h01); wr(16'h0808, 8'h01);
    wr(16'h0092, 8'h03);
    wr(16'h0800, 8'h00); wr(16'h0802, 8'h00); wr(16'h0803, 8'h00);
    wr(16'h0804, 8'h00); wr(16'h081D, 8'h00);
    wr(16'h0814, 8'h00); wr(16'h0123, 8'h00);
    check("R10 locks idle", {6'b0, lock1_toggle, lock2_toggle}, 8'h00);
    check("R10 outputs kept", {5'b0, cpu_reset, map_mode, activity_led}, 8'h07);
    rd(16'h081C, d); check("R10 sysctl kept", d, 8'h03);
    rd(16'h0092, d); check("R10 endian kept", d, 8'h02);
    rd(16'h0800, d); check("R10 cpu cfg constant", d, 8'hEF);
    rd(16'h081D, d); check("R10 cache status constant", d, 8'h03);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    rd(16'h0800, d);
    @(negedge clk); addr = 16'h0000;
    @(negedge clk); @(negedge clk);
    check("R11 rdata held", rdata, 8'hEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_port92();
    t_sysctl();
    t_map();
    t_ids();
    t_light();
    t_locks();
    t_unmapped_reads();
    t_ignored_writes();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule